// File: doc/BRIEF.md
# Rectangular Window Pixel Write Engine

This block takes a rectangular update region, given by inclusive first and last column and row coordinates, together with a pixel format code and a data source selector. On a setup request it checks that the region is usable, works out how many bytes the transfer will carry, and derives the frame buffer address of the first byte. It then takes bytes from a host data port, one per cycle when offered, and writes them into a byte-wide frame buffer port in row-major order. Each pixel's bytes are kept together, and the rows follow the screen pitch.

When the last byte of a region has been written, the region is committed into a dirty bounding box. The box only ever grows to cover the committed regions, until a clear request empties it. A downstream refresh stage reads the box and redraws what it covers, and it skips the refresh when the box is empty. A data byte that arrives while no transfer is open first triggers a setup from the current region settings, so a host can stream a new window without an explicit setup request.

Top module: `win_write_engine`

## Requirements
- R1: A setup fails when the source selector is above 3, the format maps to zero bytes per pixel, the last column is below the first, or the last row is below the first. A failed setup pulses `setup_err` for one cycle, leaves `remaining` at 0 and writes nothing.
- R2: Format codes map to bytes per pixel as follows: 1 → 1, 2 → 2, 3 and 4 (the two three-byte RGB packings) → 3, 5 and 6 (the two four-byte RGB packings) → 4. Every other code maps to 0.
- R3: After a successful setup, `remaining` holds bytes-per-pixel × (last col − first col + 1) × (last row − first row + 1) from the next cycle.
- R4: The byte with index k of a transfer is written one cycle after it is accepted. It goes to address ((first row + r) × SCREEN_W + first col + c) × bpp + (k mod bpp), where pixel p = k div bpp, c = p mod width and r = p div width. `mem_wdata` carries the byte.
- R5: Each accepted byte lowers `remaining` by exactly one.
- R6: When `remaining` reaches zero, `commit` pulses for one cycle.
- R7: A data byte that arrives while `remaining` is 0 first starts a setup from the current settings, and on success it becomes byte 0 of the new window. If that setup fails, the byte is dropped and `setup_err` pulses.
- R8: After reset the dirty box is empty: low bounds are all ones, high bounds are 0 and `dirty_any` is 0. A commit lowers the low bounds to the window's first column and row, and raises the high bounds to last + 1.
- R9: `angle` takes the 2-bit rotation field at each successful setup and holds it otherwise.
- R10: `clear_dirty` empties the box. When a commit happens in the same cycle, the box becomes exactly that window.
- R11: A setup request during an open transfer abandons the rest of that transfer and starts the new window.
- R12: A one-byte window commits on its only byte. A window touching coordinate 1023 gives a high bound of 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_first | input | COORD_W | First column of the region |
| x_last | input | COORD_W | Last column of the region (inclusive) |
| y_first | input | COORD_W | First row of the region |
| y_last | input | COORD_W | Last row of the region (inclusive) |
| pix_fmt | input | 4 | Pixel format code |
| src_sel | input | 3 | Data source selector |
| effect_cfg | input | 2 | Rotation field of the effect setting |
| setup_req | input | 1 | Explicit setup request |
| data_valid | input | 1 | Host data byte present |
| data_byte | input | 8 | Host data byte |
| clear_dirty | input | 1 | Empty the dirty box |
| mem_we | output | 1 | Frame buffer write strobe |
| mem_addr | output | ADDR_W | Frame buffer byte address |
| mem_wdata | output | 8 | Frame buffer write data |
| remaining | output | LEN_W | Bytes still owed to the open window |
| angle | output | 2 | Rotation captured at setup |
| setup_err | output | 1 | Setup rejected (one-cycle pulse) |
| commit | output | 1 | Window completed (one-cycle pulse) |
| dirty_x_lo | output | COORD_W+1 | Dirty box lowest column |
| dirty_y_lo | output | COORD_W+1 | Dirty box lowest row |
| dirty_x_hi | output | COORD_W+1 | Dirty box column bound (exclusive) |
| dirty_y_hi | output | COORD_W+1 | Dirty box row bound (exclusive) |
| dirty_any | output | 1 | Dirty box is non-empty |

## Verification
The bench targets these corner cases:
- **Row wrap in multi-byte formats.** A walker that stepped the column on every byte, or that forgot to add the screen pitch, would scatter pixels across a row.
- **Implicit setup on a data byte.** A design that lost the first byte, or kept writing after a failed setup, would shift the whole image or write garbage.
- **One-byte windows and windows on the 1023 edge.** These catch a commit that lags by a cycle and a high bound that overflows to zero.
- **A clear in the same cycle as a commit.** This exposes the wrong priority, which would leave the box either stale or empty.
- **A restart in the middle of a transfer.** This shows whether the old byte count leaks into the new window.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
  localparam int MAX_BPP = 4;
  localparam int BPP_W   = 3;

  // Format code to bytes per pixel; zero marks an unusable format.
  function automatic logic [BPP_W-1:0] bytes_per_pixel(input logic [3:0] fmt);
    case (fmt)
      4'h1:       return 3'd1;
      4'h2:       return 3'd2;
      4'h3, 4'h4: return 3'd3;
      4'h5, 4'h6: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/wpe_setup.sv
module wpe_setup
  import wpe_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int SCREEN_W = 800,
  parameter int ADDR_W   = 22,
  parameter int LEN_W    = 23
) (
  input  logic [COORD_W-1:0] x_first,
  input  logic [COORD_W-1:0] x_last,
  input  logic [COORD_W-1:0] y_first,
  input  logic [COORD_W-1:0] y_last,
  input  logic [3:0]         pix_fmt,
  input  logic [2:0]         src_sel,
  output logic               ok,
  output logic [BPP_W-1:0]   bpp,
  output logic [LEN_W-1:0]   len,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  line_step
);
  logic [COORD_W:0] span_x, span_y;

  always_comb begin
    bpp        = bytes_per_pixel(pix_fmt);
    span_x     = {1'b0, x_last} - {1'b0, x_first} + (COORD_W+1)'(1);
    span_y     = {1'b0, y_last} - {1'b0, y_first} + (COORD_W+1)'(1);
    ok         = (src_sel <= 3'd3) && (bpp != '0) &&
                 (x_last >= x_first) && (y_last >= y_first);
    len        = LEN_W'(bpp) * LEN_W'(span_x) * LEN_W'(span_y);
    start_addr = (ADDR_W'(y_first) * ADDR_W'(SCREEN_W) + ADDR_W'(x_first)) * ADDR_W'(bpp);
    line_step  = ADDR_W'(SCREEN_W) * ADDR_W'(bpp);
  end
endmodule

// File: rtl/wpe_walker.sv
module wpe_walker
  import wpe_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 22,
  parameter int LEN_W   = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               setup_req,
  input  logic               data_valid,
  input  logic [7:0]         data_byte,
  input  logic [1:0]         effect_cfg,
  input  logic [COORD_W-1:0] x_first,
  input  logic [COORD_W-1:0] x_last,
  input  logic [COORD_W-1:0] y_first,
  input  logic [COORD_W-1:0] y_last,
  input  logic               set_ok,
  input  logic [BPP_W-1:0]   set_bpp,
  input  logic [LEN_W-1:0]   set_len,
  input  logic [ADDR_W-1:0]  set_start,
  input  logic [ADDR_W-1:0]  set_step,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [LEN_W-1:0]   remaining,
  output logic [1:0]         angle,
  output logic               setup_err,
  output logic               commit,
  output logic               commit_now,
  output logic [COORD_W-1:0] win_x0,
  output logic [COORD_W-1:0] win_x1,
  output logic [COORD_W-1:0] win_y0,
  output logic [COORD_W-1:0] win_y1
);
  logic               fresh, load, fail, take, last, state_en;
  logic [LEN_W-1:0]   rem_q, rem_d, cur_rem;
  logic [ADDR_W-1:0]  addr_q, addr_d, cur_addr, base_q, base_d, cur_base, step_q, cur_step;
  logic [COORD_W-1:0] col_q, col_d, cur_col;
  logic [COORD_W-1:0] xs_q, xe_q, ys_q, ye_q, cur_xs, cur_xe, cur_ys, cur_ye;
  logic [BPP_W-1:0]   bidx_q, bidx_d, cur_bidx, bpp_q, cur_bpp;
  logic [1:0]         angle_q;
  logic               we_q, err_q, commit_q;
  logic [ADDR_W-1:0]  waddr_q;
  logic [7:0]         wdata_q;

  // Next-state: a fresh setup overrides the held window in the same cycle.
  always_comb begin
    fresh    = setup_req | (data_valid & (rem_q == '0));
    load     = fresh & set_ok;
    fail     = fresh & ~set_ok;
    cur_rem  = load ? set_len : (fail ? '0 : rem_q);
    cur_addr = load ? set_start : addr_q;
    cur_base = load ? set_start : base_q;
    cur_step = load ? set_step : step_q;
    cur_col  = load ? x_first : col_q;
    cur_bidx = load ? '0 : bidx_q;
    cur_bpp  = load ? set_bpp : bpp_q;
    cur_xs   = load ? x_first : xs_q;
    cur_xe   = load ? x_last : xe_q;
    cur_ys   = load ? y_first : ys_q;
    cur_ye   = load ? y_last : ye_q;
    take     = data_valid & (cur_rem != '0);
    last     = take & (cur_rem == LEN_W'(1));
    rem_d    = cur_rem;
    addr_d   = cur_addr;
    base_d   = cur_base;
    col_d    = cur_col;
    bidx_d   = cur_bidx;
    if (take) begin
      rem_d = cur_rem - LEN_W'(1);
      if (cur_bidx == cur_bpp - BPP_W'(1)) begin
        bidx_d = '0;
        if (cur_col == cur_xe) begin
          col_d  = cur_xs;
          base_d = cur_base + cur_step;
          addr_d = cur_base + cur_step;
        end else begin
          col_d  = cur_col + COORD_W'(1);
          addr_d = cur_addr + ADDR_W'(1);
        end
      end else begin
        bidx_d = cur_bidx + BPP_W'(1);
        addr_d = cur_addr + ADDR_W'(1);
      end
    end
    state_en = fresh | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; addr_q <= '0; base_q <= '0; step_q <= '0; col_q <= '0;
      bidx_q <= '0; bpp_q <= '0; xs_q <= '0; xe_q <= '0; ys_q <= '0; ye_q <= '0;
      angle_q <= '0; we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0;
      err_q <= 1'b0; commit_q <= 1'b0;
    end else begin
      if (state_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
        base_q <= base_d;
        col_q  <= col_d;
        bidx_q <= bidx_d;
      end
      if (load) begin
        step_q  <= set_step;
        bpp_q   <= set_bpp;
        xs_q    <= x_first;
        xe_q    <= x_last;
        ys_q    <= y_first;
        ye_q    <= y_last;
        angle_q <= effect_cfg;
      end
      we_q <= take;
      if (take) begin
        waddr_q <= cur_addr;
        wdata_q <= data_byte;
      end
      err_q    <= fail;
      commit_q <= last;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = waddr_q;
  assign mem_wdata  = wdata_q;
  assign remaining  = rem_q;
  assign angle      = angle_q;
  assign setup_err  = err_q;
  assign commit     = commit_q;
  assign commit_now = last;
  assign win_x0     = cur_xs;
  assign win_x1     = cur_xe;
  assign win_y0     = cur_ys;
  assign win_y1     = cur_ye;

  p_rem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0 && data_valid && !setup_req) |=> rem_q == $past(rem_q) - LEN_W'(1));
  p_commit_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> rem_q == '0);
  p_err_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!we_q && rem_q == '0));
endmodule

// File: rtl/wpe_dirty.sv
module wpe_dirty #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_dirty,
  input  logic               merge,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_y1,
  output logic [COORD_W:0]   x_lo,
  output logic [COORD_W:0]   y_lo,
  output logic [COORD_W:0]   x_hi,
  output logic [COORD_W:0]   y_hi,
  output logic               dirty_any
);
  localparam logic [COORD_W:0] EMPTY_LO = '1;
  logic [COORD_W:0] xlo_q, ylo_q, xhi_q, yhi_q, xlo_d, ylo_d, xhi_d, yhi_d;
  logic [COORD_W:0] ex0, ex1, ey0, ey1;
  logic             box_en;

  always_comb begin
    ex0 = {1'b0, win_x0};
    ey0 = {1'b0, win_y0};
    ex1 = {1'b0, win_x1} + (COORD_W+1)'(1);
    ey1 = {1'b0, win_y1} + (COORD_W+1)'(1);
    xlo_d = clear_dirty ? EMPTY_LO : xlo_q;
    ylo_d = clear_dirty ? EMPTY_LO : ylo_q;
    xhi_d = clear_dirty ? '0 : xhi_q;
    yhi_d = clear_dirty ? '0 : yhi_q;
    if (merge) begin
      if (ex0 < xlo_d) xlo_d = ex0;
      if (ey0 < ylo_d) ylo_d = ey0;
      if (ex1 > xhi_d) xhi_d = ex1;
      if (ey1 > yhi_d) yhi_d = ey1;
    end
    box_en = clear_dirty | merge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlo_q <= EMPTY_LO; ylo_q <= EMPTY_LO; xhi_q <= '0; yhi_q <= '0;
    end else if (box_en) begin
      xlo_q <= xlo_d; ylo_q <= ylo_d; xhi_q <= xhi_d; yhi_q <= yhi_d;
    end
  end

  assign x_lo = xlo_q;
  assign y_lo = ylo_q;
  assign x_hi = xhi_q;
  assign y_hi = yhi_q;
  assign dirty_any = (xhi_q > xlo_q) && (yhi_q > ylo_q);

  p_box_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_dirty |=> (x_lo <= $past(x_lo) && y_lo <= $past(y_lo) &&
                      x_hi >= $past(x_hi) && y_hi >= $past(y_hi)));
  p_merge_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    merge |=> dirty_any);
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_dirty && !merge) |=> !dirty_any);
endmodule

// File: rtl/win_write_engine.sv
module win_write_engine
  import wpe_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int SCREEN_W = 800,
  localparam int ADDR_W  = $clog2(SCREEN_W * (1 << COORD_W) * MAX_BPP),
  localparam int LEN_W   = $clog2(MAX_BPP * (1 << COORD_W) * (1 << COORD_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] x_first,
  input  logic [COORD_W-1:0] x_last,
  input  logic [COORD_W-1:0] y_first,
  input  logic [COORD_W-1:0] y_last,
  input  logic [3:0]         pix_fmt,
  input  logic [2:0]         src_sel,
  input  logic [1:0]         effect_cfg,
  input  logic               setup_req,
  input  logic               data_valid,
  input  logic [7:0]         data_byte,
  input  logic               clear_dirty,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [LEN_W-1:0]   remaining,
  output logic [1:0]         angle,
  output logic               setup_err,
  output logic               commit,
  output logic [COORD_W:0]   dirty_x_lo,
  output logic [COORD_W:0]   dirty_y_lo,
  output logic [COORD_W:0]   dirty_x_hi,
  output logic [COORD_W:0]   dirty_y_hi,
  output logic               dirty_any
);
  logic               set_ok, commit_now;
  logic [BPP_W-1:0]   set_bpp;
  logic [LEN_W-1:0]   set_len;
  logic [ADDR_W-1:0]  set_start, set_step;
  logic [COORD_W-1:0] wx0, wx1, wy0, wy1;

  wpe_setup #(.COORD_W(COORD_W), .SCREEN_W(SCREEN_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_setup (
    .x_first(x_first), .x_last(x_last), .y_first(y_first), .y_last(y_last),
    .pix_fmt(pix_fmt), .src_sel(src_sel), .ok(set_ok), .bpp(set_bpp),
    .len(set_len), .start_addr(set_start), .line_step(set_step));

  wpe_walker #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .setup_req(setup_req), .data_valid(data_valid),
    .data_byte(data_byte), .effect_cfg(effect_cfg),
    .x_first(x_first), .x_last(x_last), .y_first(y_first), .y_last(y_last),
    .set_ok(set_ok), .set_bpp(set_bpp), .set_len(set_len),
    .set_start(set_start), .set_step(set_step),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .remaining(remaining), .angle(angle), .setup_err(setup_err), .commit(commit),
    .commit_now(commit_now), .win_x0(wx0), .win_x1(wx1), .win_y0(wy0), .win_y1(wy1));

  wpe_dirty #(.COORD_W(COORD_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .clear_dirty(clear_dirty), .merge(commit_now),
    .win_x0(wx0), .win_x1(wx1), .win_y0(wy0), .win_y1(wy1),
    .x_lo(dirty_x_lo), .y_lo(dirty_y_lo), .x_hi(dirty_x_hi), .y_hi(dirty_y_hi),
    .dirty_any(dirty_any));

  p_commit_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> dirty_any);
endmodule

// File: tb/win_write_engine_bench.sv
module win_write_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 800;
  localparam int AW = 22;
  localparam int LW = 23;

  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] x_first, x_last, y_first, y_last;
  logic [3:0] pix_fmt;
  logic [2:0] src_sel;
  logic [1:0] effect_cfg;
  logic setup_req, data_valid, clear_dirty;
  logic [7:0] data_byte;
  logic mem_we, setup_err, commit, dirty_any;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [LW-1:0] remaining;
  logic [1:0] angle;
  logic [10:0] dirty_x_lo, dirty_y_lo, dirty_x_hi, dirty_y_hi;

  int checks = 0;
  int fails = 0;

  win_write_engine #(.COORD_W(10), .SCREEN_W(SW)) u_win_write_engine (
    .clk(clk), .rst_n(rst_n), .x_first(x_first), .x_last(x_last),
    .y_first(y_first), .y_last(y_last), .pix_fmt(pix_fmt), .src_sel(src_sel),
    .effect_cfg(effect_cfg), .setup_req(setup_req), .data_valid(data_valid),
    .data_byte(data_byte), .clear_dirty(clear_dirty), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .remaining(remaining),
    .angle(angle), .setup_err(setup_err), .commit(commit),
    .dirty_x_lo(dirty_x_lo), .dirty_y_lo(dirty_y_lo), .dirty_x_hi(dirty_x_hi),
    .dirty_y_hi(dirty_y_hi), .dirty_any(dirty_any));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int bpp_of(input int f);
    if (f == 1) return 1;
    if (f == 2) return 2;
    if (f == 3 || f == 4) return 3;
    if (f == 5 || f == 6) return 4;
    return 0;
  endfunction

  // Behavioural reference model
  int m_rem, m_total, m_b, m_w, m_xs, m_ys, m_xe, m_ye, k, p, b;
  bit fresh_m, ok_m;
  int e_we, e_addr, e_data, e_rem, e_commit, e_err, e_angle;
  int e_xlo, e_ylo, e_xhi, e_yhi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_total = 0; m_b = 1; m_w = 1; m_xs = 0; m_ys = 0; m_xe = 0; m_ye = 0;
      e_we = 0; e_addr = 0; e_data = 0; e_rem = 0; e_commit = 0; e_err = 0; e_angle = 0;
      e_xlo = 2047; e_ylo = 2047; e_xhi = 0; e_yhi = 0;
    end else begin
      e_we = 0; e_err = 0; e_commit = 0;
      fresh_m = setup_req || (data_valid && m_rem == 0);
      if (fresh_m) begin
        b = bpp_of(pix_fmt);
        ok_m = (src_sel <= 3) && (b != 0) && (x_last >= x_first) && (y_last >= y_first);
        if (ok_m) begin
          m_xs = x_first; m_xe = x_last; m_ys = y_first; m_ye = y_last; m_b = b;
          m_w = m_xe - m_xs + 1;
          m_total = b * m_w * (m_ye - m_ys + 1);
          m_rem = m_total;
          e_angle = effect_cfg;
        end else begin
          m_rem = 0;
          e_err = 1;
        end
      end
      if (clear_dirty) begin
        e_xlo = 2047; e_ylo = 2047; e_xhi = 0; e_yhi = 0;
      end
      if (data_valid && m_rem > 0) begin
        k = m_total - m_rem;
        p = k / m_b;
        e_addr = ((m_ys + p / m_w) * SW + m_xs + p % m_w) * m_b + k % m_b;
        e_data = data_byte;
        e_we = 1;
        m_rem--;
        if (m_rem == 0) begin
          e_commit = 1;
          if (m_xs < e_xlo) e_xlo = m_xs;
          if (m_ys < e_ylo) e_ylo = m_ys;
          if (m_xe + 1 > e_xhi) e_xhi = m_xe + 1;
          if (m_ye + 1 > e_yhi) e_yhi = m_ye + 1;
        end
      end
      e_rem = m_rem;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 mem_we", mem_we, e_we);
      if (e_we != 0) begin
        chk("R4 mem_addr", mem_addr, e_addr);
        chk("R4 mem_wdata", mem_wdata, e_data);
      end
      chk("R5 remaining", remaining, e_rem);
      chk("R6 commit", commit, e_commit);
      chk("R1 setup_err", setup_err, e_err);
      chk("R9 angle", angle, e_angle);
      chk("R8 dirty_x_lo", dirty_x_lo, e_xlo);
      chk("R8 dirty_y_lo", dirty_y_lo, e_ylo);
      chk("R8 dirty_x_hi", dirty_x_hi, e_xhi);
      chk("R8 dirty_y_hi", dirty_y_hi, e_yhi);
    end
  end

  task automatic win(input int xs, input int xe, input int ys, input int ye,
                     input int f, input int s, input int fx);
    x_first = 10'(xs); x_last = 10'(xe); y_first = 10'(ys); y_last = 10'(ye);
    pix_fmt = 4'(f); src_sel = 3'(s); effect_cfg = 2'(fx);
  endtask

  task automatic cyc(input bit su, input bit dv, input int d, input bit clr);
    setup_req = su; data_valid = dv; data_byte = 8'(d); clear_dirty = clr;
    @(negedge clk);
    setup_req = 1'b0; data_valid = 1'b0; clear_dirty = 1'b0;
  endtask

  task automatic stream(input int n, input int seed);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, seed + i * 7, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    setup_req = 1'b0; data_valid = 1'b0; clear_dirty = 1'b0; data_byte = '0;
    win(0, 0, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset remaining", remaining, 0);
    chk("R8 reset dirty_any", dirty_any, 0);
    chk("R8 reset x_lo", dirty_x_lo, 2047);

    // R2 R3 R9: three-byte format, 3x2 window
    win(10, 12, 5, 6, 3, 0, 2);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R3 length 3bpp", remaining, 18);
    chk("R9 angle captured", angle, 2);
    stream(17, 1);
    cyc(1'b0, 1'b1, 99, 1'b0);
    chk("R6 commit pulse", commit, 1);
    chk("R8 x_hi after commit", dirty_x_hi, 13);
    chk("R8 y_lo after commit", dirty_y_lo, 5);

    // R1 R2 rejections
    win(12, 10, 5, 6, 3, 0, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R1 x_last<x_first err", setup_err, 1);
    chk("R1 remaining zero", remaining, 0);
    win(1, 2, 6, 5, 3, 0, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R1 y_last<y_first err", setup_err, 1);
    win(1, 2, 1, 2, 3, 4, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R1 source>3 err", setup_err, 1);
    win(1, 2, 1, 2, 0, 0, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R2 format 0 rejected", setup_err, 1);
    win(1, 2, 1, 2, 7, 0, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R2 format 7 rejected", setup_err, 1);
    chk("R9 angle kept on failure", angle, 2);

    // R7 implicit setup, four-byte format
    win(0, 1, 0, 0, 5, 3, 3);
    cyc(1'b0, 1'b1, 8'hA5, 1'b0);
    chk("R7 first byte written", mem_we, 1);
    chk("R7 first byte addr", mem_addr, 0);
    chk("R7 remaining after first", remaining, 7);
    stream(7, 20);
    chk("R8 grown x_lo", dirty_x_lo, 0);
    chk("R8 grown x_hi", dirty_x_hi, 13);

    // R7 failed implicit setup drops the byte
    win(0, 1, 0, 0, 0, 0, 0);
    cyc(1'b0, 1'b1, 8'h3C, 1'b0);
    chk("R7 failed setup err", setup_err, 1);
    chk("R7 byte dropped", mem_we, 0);

    // R11 restart mid-transfer
    win(100, 101, 200, 201, 2, 1, 1);
    cyc(1'b1, 1'b0, 0, 1'b0);
    stream(3, 40);
    chk("R11 partial remaining", remaining, 5);
    win(1017, 1019, 3, 3, 1, 2, 0);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R11 restart remaining", remaining, 3);
    stream(3, 60);

    // R12 one-byte window at the far corner
    win(1023, 1023, 1023, 1023, 1, 0, 0);
    cyc(1'b0, 1'b1, 8'h77, 1'b0);
    chk("R12 single byte commit", commit, 1);
    chk("R12 x_hi at edge", dirty_x_hi, 1024);
    chk("R12 y_hi at edge", dirty_y_hi, 1024);

    // R10 clear, then clear together with a commit
    cyc(1'b0, 1'b0, 0, 1'b1);
    chk("R10 cleared", dirty_any, 0);
    chk("R10 cleared x_lo", dirty_x_lo, 2047);
    win(3, 3, 4, 4, 1, 0, 0);
    cyc(1'b1, 1'b0, 0, 1'b0);
    cyc(1'b0, 1'b1, 8'h11, 1'b1);
    chk("R10 clear+commit x_lo", dirty_x_lo, 3);
    chk("R10 clear+commit x_hi", dirty_x_hi, 4);
    chk("R10 clear+commit y_hi", dirty_y_hi, 5);

    // Gapped streams across several formats
    for (int w = 0; w < 6; w++) begin
      win(20 + w, 22 + 2 * w, 30 + w, 31 + w, 1 + w, w % 4, w % 4);
      cyc(1'b1, 1'b0, 0, 1'b0);
      for (int i = 0; i < 80; i++) cyc(1'b0, ((i * 5 + w) % 3) != 0, i * 3 + w, 1'b0);
    end

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule